// File: doc/BRIEF.md
# Pin Multiplexer with Qualified Inputs and Wake Request

This block sits between a bank of device pins and the internal peripheral signals that share them. Each pin is set on its own to general-purpose mode or to peripheral mode. In general-purpose mode a data-out register drives the pin, and a direction register decides whether the pin is driven at all. In peripheral mode the peripheral's own output value and output enable reach the pin. All pins come up from reset as undriven general-purpose inputs.

Every incoming pin level passes through a two-flop synchronizer. It may then pass through a qualification filter. The filter accepts a new level only after the level has been sampled unchanged for a programmed number of consecutive clocks, so short noise glitches are dropped. The qualified levels are read through the register port and go to the peripherals. A level-type wake request is raised while any wake-enabled pin sits at its programmed wake level. Software configures the block through a simple write-strobe and combinational-read register port.

Each pin has its own qualification filter, a small state machine with two states. In `QS_STEADY` the qualified output matches the synchronized input. The transition *mismatch seen* moves the filter to `QS_TRACK`, where it counts consecutive samples that disagree with the output. The transition *level accepted* updates the output and returns to `QS_STEADY`. The transition *glitch dropped* is taken when a sample agrees with the output again; it returns to `QS_STEADY` without updating the output. When the filter is bypassed, the output follows the synchronizer on every clock and the filter stays in `QS_STEADY`.

Top module: `gpio_qual_mux`

## Requirements
- R1: After reset, every pin is in general-purpose mode and configured as an input, so `pad_oe` is all zero. The data-out, qualification-count, qualification-select and wake registers are all zero.
- R2: Register address 0 holds one mode bit per pin, where 1 selects peripheral mode. For a pin in peripheral mode, `pad_oe` and `pad_out` equal that pin's bits of `per_oe` and `per_out`.
- R3: For a pin in general-purpose mode, `pad_oe` equals its bit in the direction register at address 1 (1 = drive) and `pad_out` equals its bit in the data-out register at address 2.
- R4: Writing the data-out register has no effect on the `pad_out` bit of any pin that is in peripheral mode.
- R5: For a filtered pin with a count N of 1 or more, the qualified value takes a new level only after the synchronized input has shown that level for N consecutive clocks. A pin change made between clock edges appears in the qualified value on the (2+N)-th rising edge. A pulse lasting N-1 clocks is rejected, and a pulse lasting exactly N clocks is accepted.
- R6: A pin is bypassed when its qualification-select bit is 0 or the count is 0. A bypassed pin's qualified value follows the pin after the two-flop synchronizer only, and a change shows on the third rising edge.
- R7: Address 6 holds the single count N, in its low 4 bits, and this count is shared by all pins. Address 7 holds one qualification-select bit per pin, so filtered and bypassed pins can coexist.
- R8: Reading address 3 returns the qualified input of every pin, in either mode. `per_in` carries the same qualified values. Writes to address 3 are ignored.
- R9: `wake_req` is high exactly while some pin has its wake-enable bit set (address 4) and its qualified value equals its wake-polarity bit (address 5).
- R10: A value written to addresses 0, 1, 2, 4, 5 or 7 reads back unchanged. Address 6 reads back as its 4-bit count, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pad_in | input | 8 | Raw levels from the pins |
| pad_out | output | 8 | Level driven toward each pin |
| pad_oe | output | 8 | Output enable per pin |
| per_out | input | 8 | Peripheral output values |
| per_oe | input | 8 | Peripheral output enables |
| per_in | output | 8 | Qualified pin levels to the peripherals |
| wake_req | output | 1 | Wake request level |

## Verification
A filter stuck in `QS_TRACK`, or one whose count is off by one, shows at the input-data register and at `per_in`. The effect appears on the edge where a level should have been accepted or rejected, so the bench samples exactly on the (2+N)-th edge and one edge before it. A wrong mode or direction bit shows at `pad_oe` and `pad_out` within one clock of the register write. A wrong qualified value shows on `wake_req` in the same cycle that the filter output changes.

// File: rtl/gpio_qual_pkg.sv
package gpio_qual_pkg;

    typedef enum logic [2:0] {
        A_MODE  = 3'd0,
        A_DIR   = 3'd1,
        A_DOUT  = 3'd2,
        A_DIN   = 3'd3,
        A_WKEN  = 3'd4,
        A_WKPOL = 3'd5,
        A_QCNT  = 3'd6,
        A_QSEL  = 3'd7
    } reg_addr_e;

    typedef enum logic {
        QS_STEADY = 1'b0,
        QS_TRACK  = 1'b1
    } qual_state_e;

endpackage

// File: rtl/gpio_qual_regs.sv
module gpio_qual_regs
    import gpio_qual_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [2:0]       addr,
    input  logic [NPINS-1:0] wdata,
    input  logic [NPINS-1:0] din,
    output logic [NPINS-1:0] rdata,
    output logic [NPINS-1:0] mode_o,
    output logic [NPINS-1:0] dir_o,
    output logic [NPINS-1:0] dout_o,
    output logic [NPINS-1:0] wken_o,
    output logic [NPINS-1:0] wkpol_o,
    output logic [CNT_W-1:0] qcnt_o,
    output logic [NPINS-1:0] qsel_o
);
    localparam int PAD_W = NPINS - CNT_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o  <= '0;
            dir_o   <= '0;
            dout_o  <= '0;
            wken_o  <= '0;
            wkpol_o <= '0;
            qcnt_o  <= '0;
            qsel_o  <= '0;
        end else if (we) begin
            unique case (reg_addr_e'(addr))
                A_MODE:  mode_o  <= wdata;
                A_DIR:   dir_o   <= wdata;
                A_DOUT:  dout_o  <= wdata;
                A_WKEN:  wken_o  <= wdata;
                A_WKPOL: wkpol_o <= wdata;
                A_QCNT:  qcnt_o  <= wdata[CNT_W-1:0];
                A_QSEL:  qsel_o  <= wdata;
                A_DIN:   ;
            endcase
        end
    end

    always_comb begin
        unique case (reg_addr_e'(addr))
            A_MODE:  rdata = mode_o;
            A_DIR:   rdata = dir_o;
            A_DOUT:  rdata = dout_o;
            A_DIN:   rdata = din;
            A_WKEN:  rdata = wken_o;
            A_WKPOL: rdata = wkpol_o;
            A_QCNT:  rdata = {{PAD_W{1'b0}}, qcnt_o};
            A_QSEL:  rdata = qsel_o;
        endcase
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (mode_o == '0 && dir_o == '0 && dout_o == '0 && qcnt_o == '0));

endmodule

// File: rtl/gpio_qual_filter.sv
module gpio_qual_filter
    import gpio_qual_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             filt_en,
    input  logic [CNT_W-1:0] limit,
    output logic             q_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             s1, s2;
    logic [CNT_W-1:0] cnt;
    logic             bypass;
    logic             reach;
    qual_state_e      state_q, state_d;

    assign bypass = !filt_en || (limit == '0);
    assign reach  = ({1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= pin_i;
            s2 <= s1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= QS_STEADY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            QS_STEADY: if (!bypass && s2 != q_o && limit != ONE) state_d = QS_TRACK;
            QS_TRACK:  if (bypass || s2 == q_o || reach)        state_d = QS_STEADY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= 1'b0;
            cnt <= '0;
        end else if (bypass) begin
            q_o <= s2;
            cnt <= '0;
        end else begin
            unique case (state_q)
                QS_STEADY: begin
                    if (s2 != q_o) begin
                        if (limit == ONE) q_o <= s2;
                        else              cnt <= ONE;
                    end
                end
                QS_TRACK: begin
                    if (s2 == q_o) begin
                        cnt <= '0;
                    end else if (reach) begin
                        q_o <= s2;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
            endcase
        end
    end

    // R6
    follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q_o) |-> (q_o == $past(s2)));

    // R5
    needs_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!bypass) && $past(limit) > ONE && !$stable(q_o)) |-> ($past(state_q) == QS_TRACK));

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == QS_TRACK) |-> (cnt < limit));

endmodule

// File: rtl/gpio_qual_mux.sv
module gpio_qual_mux
    import gpio_qual_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [NPINS-1:0] reg_wdata,
    output logic [NPINS-1:0] reg_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    input  logic [NPINS-1:0] per_out,
    input  logic [NPINS-1:0] per_oe,
    output logic [NPINS-1:0] per_in,
    output logic             wake_req
);
    logic [NPINS-1:0] mode_w, dir_w, dout_w, wken_w, wkpol_w, qsel_w, qual_w;
    logic [CNT_W-1:0] qcnt_w;

    gpio_qual_regs #(.NPINS(NPINS), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .din(qual_w), .rdata(reg_rdata), .mode_o(mode_w), .dir_o(dir_w),
        .dout_o(dout_w), .wken_o(wken_w), .wkpol_o(wkpol_w), .qcnt_o(qcnt_w),
        .qsel_o(qsel_w)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_qual_filter #(.CNT_W(CNT_W)) filt_i (
            .clk(clk), .rst_n(rst_n), .pin_i(pad_in[i]), .filt_en(qsel_w[i]),
            .limit(qcnt_w), .q_o(qual_w[i])
        );
        assign pad_oe[i]  = mode_w[i] ? per_oe[i]  : dir_w[i];
        assign pad_out[i] = mode_w[i] ? per_out[i] : dout_w[i];
    end

    assign per_in   = qual_w;
    assign wake_req = |(wken_w & ~(qual_w ^ wkpol_w));

    // R4
    dout_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_we && reg_addr == A_DOUT) && $stable(mode_w) && $stable(per_out))
        |-> (((pad_out ^ $past(pad_out)) & mode_w) == '0));

    // R9
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wken_w == '0) |-> !wake_req);

    // R1
    reset_undriven_chk: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (pad_oe == (mode_w & per_oe)));

endmodule

// File: tb/gpio_qual_mux_tb.sv
module gpio_qual_mux_tb_top;
    import gpio_qual_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       reg_we = 0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe, per_in;
    logic [7:0] per_out = '0;
    logic [7:0] per_oe = '0;
    logic       wake_req;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_qual_mux dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .per_out(per_out), .per_oe(per_oe),
        .per_in(per_in), .wake_req(wake_req)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            wait (q.size() > 0);
            #1;
            begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.sel)
                    0: act = reg_rdata;
                    1: act = pad_out;
                    2: act = pad_oe;
                    3: act = per_in;
                    default: act = {7'd0, wake_req};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic chk(input int sel, input logic [7:0] exp, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
        #1;
    endtask

    task automatic rd(input reg_addr_e a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        chk(0, exp, tag);
    endtask

    task automatic wr(input reg_addr_e a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0; reg_addr = A_DIN;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        rd(A_MODE, 8'h00, "R1 mode");
        rd(A_DIR,  8'h00, "R1 dir");
        chk(2, 8'h00, "R1 pad_oe");
        rd(A_QCNT, 8'h00, "R1 qcnt");

        // R3 general-purpose output
        wr(A_DIR, 8'hFF);
        wr(A_DOUT, 8'hA5);
        chk(2, 8'hFF, "R3 pad_oe");
        chk(1, 8'hA5, "R3 pad_out");

        // R2 peripheral mode on low nibble
        per_oe = 8'h0C; per_out = 8'h03;
        wr(A_MODE, 8'h0F);
        chk(2, 8'hFC, "R2 pad_oe");
        chk(1, 8'hA3, "R2 pad_out");
        // R4 data-out ignored on peripheral pins
        wr(A_DOUT, 8'h5A);
        chk(1, 8'h53, "R4 pad_out");

        // R10 readback
        rd(A_MODE, 8'h0F, "R10 mode");
        rd(A_DOUT, 8'h5A, "R10 dout");
        wr(A_QCNT, 8'hF4);
        rd(A_QCNT, 8'h04, "R10 qcnt");
        wr(A_QCNT, 8'h00);
        wr(A_DIR, 8'h00);

        // R6 bypass latency, R8 read in both modes
        @(negedge clk) pad_in = 8'h3C;
        repeat (2) @(posedge clk);
        chk(0, 8'h00, "R6 before third edge");
        @(posedge clk);
        chk(0, 8'h3C, "R6 third edge");
        chk(3, 8'h3C, "R8 per_in");
        wr(A_DIN, 8'hFF);
        rd(A_DIN, 8'h3C, "R8 din write ignored");

        // R5 filtered, N=4
        wr(A_QCNT, 8'h04);
        wr(A_QSEL, 8'hFF);
        @(negedge clk) pad_in = 8'h3D;
        repeat (5) @(posedge clk);
        chk(0, 8'h3C, "R5 edge 2+N-1");
        @(posedge clk);
        chk(0, 8'h3D, "R5 edge 2+N");

        @(negedge clk) pad_in = 8'h3F;
        repeat (3) @(negedge clk);
        pad_in = 8'h3D;
        repeat (10) @(posedge clk);
        chk(0, 8'h3D, "R5 short pulse rejected");

        @(negedge clk) pad_in = 8'h3F;
        repeat (4) @(negedge clk);
        pad_in = 8'h3D;
        repeat (2) @(posedge clk);
        chk(0, 8'h3F, "R5 N-clock pulse accepted");
        repeat (10) @(posedge clk);
        chk(0, 8'h3D, "R5 pulse end accepted");

        // R7 per-pin select: bit0 bypassed while count is 4
        wr(A_QSEL, 8'hFE);
        @(negedge clk) pad_in = 8'h3C;
        repeat (3) @(posedge clk);
        chk(0, 8'h3C, "R7 bypassed pin");

        // R9 wake on bit2 low
        wr(A_WKEN, 8'h04);
        wr(A_WKPOL, 8'h00);
        chk(4, 8'h00, "R9 no match");
        @(negedge clk) pad_in = 8'h38;
        repeat (5) @(posedge clk);
        chk(4, 8'h00, "R9 before qualified");
        @(posedge clk);
        chk(4, 8'h01, "R9 match");
        wr(A_WKPOL, 8'h04);
        chk(4, 8'h00, "R9 polarity flip");
        wr(A_WKPOL, 8'h00);
        wr(A_WKEN, 8'h00);
        chk(4, 8'h00, "R9 disabled");

        done = 1;
        finish_run();
    end

endmodule